// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block gathers 32 interrupt lines and offers them to a small cluster of CPUs (four by default). Every line lands as a pending bit in a separate slot for each CPU. Each CPU has its own arbiter. The arbiter names the most urgent interrupt that is pending, enabled and not masked by priority, and drives that CPU's request line.

A CPU takes an interrupt by pulsing its acknowledge strobe for one cycle. In that cycle the strobe returns the selected ID and clears pending state according to the ID's sharing model:

- **Shared (1-N) model:** one CPU taking the ID clears it for every CPU.
- **Private (N-N) model:** only the taking CPU's slot is cleared.

Software reaches the configuration through a small register bus that works one field per access. Each access carries the accessing CPU's number. That number lets some fields be banked per CPU and lets others read back as a value tied to that CPU. Several fields are hard-wired and cannot be written.

Top module: `irqdist_top`

## Requirements
- R1: Configuration bit 1 of an ID selects its trigger. With value 1, a rising edge on the line sets pending. With value 0, the line sets pending in every cycle it is high, so an acknowledge does not clear it while the line stays high.
- R2: When configuration bit 0 is 1 (shared model), an acknowledge by any CPU clears that ID's pending state on all CPUs. This holds when several CPUs acknowledge it in the same cycle.
- R3: When configuration bit 0 is 0 (private model), an acknowledge clears pending only for the acknowledging CPU.
- R4: Priority is the upper nibble of the 8-bit priority field, and the lower nibble reads as zero. A smaller value is more urgent. Nibble 0xF keeps the ID from ever being signalled to that CPU.
- R5: Bus field encoding is 0 = enable (bit 0), 1 = priority, 2 = target, 3 = configuration (bits 1:0). Enable reads as 1 for IDs 0–15, and writes to it are ignored. An ID whose enable is 0 is never signalled.
- R6: Priority for IDs 0–15 and 29–31 has a separate copy for each CPU, chosen by the accessing CPU number. Priority for IDs 16–28 is shared by all CPUs.
- R7: Target reads as the one-hot code of the accessing CPU for IDs 29–31 and as zero for IDs 0–28. Writes to target are ignored.
- R8: Configuration bit 1 reads as 1 for IDs 0–15, and writes to it are ignored. For IDs 29 and 30 the whole configuration reads as binary 10 and cannot be written.
- R9: An ID at or above the implemented count (32) reads as zero in every field, and writes to it change nothing.
- R10: Among candidates with equal priority, the lower ID wins. A CPU with no candidate has its request line low and reports ID 1023.
- R11: An acknowledge returns the selected ID in the same cycle and clears pending at the next edge. If a new rising edge arrives in that same cycle, the new edge wins and the ID stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | 2 | Number of the accessing CPU |
| bus_field | input | 2 | Field selector (see R5) |
| bus_id | input | 6 | Interrupt ID addressed |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current access |
| irq_in | input | 32 | Interrupt source lines, one per ID |
| ack | input | 4 | One-cycle acknowledge strobe per CPU |
| cpu_irq | output | 4 | Request line per CPU |
| ack_id | output | 40 | Selected ID per CPU, 10 bits each, CPU n at bits 10n+9:10n |

## Verification
Two pairs of events can fall in the same cycle.

- **Two CPUs acknowledging the same shared-model ID:** the bench raises one such ID and pulses both acknowledge strobes on one edge. It checks that both strobes return that ID and that the other CPUs see it disappear afterwards.
- **A private-model acknowledge meeting a fresh rising edge on the same line:** the bench drops the line, then raises it again in the very cycle the acknowledge is held. It checks that the ID is still pending for that CPU afterwards and that a second acknowledge then clears it.

// File: rtl/irqdist_pkg.sv
`timescale 1ns/1ps
package irqdist_pkg;

    localparam int          ID_W       = 10;
    localparam logic [9:0]  NO_IRQ_ID  = 10'd1023;
    localparam int          LOW_FIXED  = 16;   // IDs below this are fixed-enable / edge
    localparam logic [3:0]  PRIO_MASK  = 4'hF;

    typedef enum logic [1:0] {
        FLD_ENABLE = 2'd0,
        FLD_PRIO   = 2'd1,
        FLD_TARGET = 2'd2,
        FLD_CONFIG = 2'd3
    } field_e;

    // Priority kept per CPU for these IDs
    function automatic logic is_banked(input int unsigned id);
        return (id < 16) || (id >= 29 && id <= 31);
    endfunction

    // Configuration hard-wired to edge / private model
    function automatic logic is_locked_cfg(input int unsigned id);
        return (id == 29) || (id == 30);
    endfunction

    // CPU-private IDs whose target reads back the accessing CPU
    function automatic logic is_self_target(input int unsigned id);
        return (id >= 29) && (id <= 31);
    endfunction

endpackage

// File: rtl/irqdist_regs.sv
`timescale 1ns/1ps
module irqdist_regs
    import irqdist_pkg::*;
#(
    parameter int NCPU    = 4,
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 6,
    localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_valid,
    input  logic                                 bus_write,
    input  logic [CPU_W-1:0]                     bus_cpu,
    input  logic [1:0]                           bus_field,
    input  logic [ADDR_W-1:0]                    bus_id,
    input  logic [7:0]                           bus_wdata,
    output logic [7:0]                           bus_rdata,
    output logic [NUM_IRQ-1:0]                   en_o,
    output logic [NUM_IRQ-1:0]                   edge_o,
    output logic [NUM_IRQ-1:0]                   shared_o,
    output logic [NCPU-1:0][NUM_IRQ-1:0][3:0]    prio_o
);

    typedef struct packed {
        logic [NUM_IRQ-1:0]                en;
        logic [NUM_IRQ-1:0]                trig_edge;
        logic [NUM_IRQ-1:0]                shared;
        logic [NUM_IRQ-1:0][3:0]           prio_sh;
        logic [NCPU-1:0][NUM_IRQ-1:0][3:0] prio_bk;
    } regs_t;

    regs_t s_d, s_q;

    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign in_range = (32'(bus_id) < NUM_IRQ);
    assign idx      = bus_id[IDX_W-1:0];

    function automatic regs_t reset_state();
        regs_t r;
        r = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            r.en[i]        = (i < LOW_FIXED);
            r.trig_edge[i] = (i < LOW_FIXED) || is_locked_cfg(i);
            r.shared[i]    = 1'b0;
        end
        return r;
    endfunction

    // next-state
    always_comb begin
        s_d = s_q;
        if (bus_valid && bus_write && in_range) begin
            case (field_e'(bus_field))
                FLD_ENABLE: begin
                    if (32'(idx) >= LOW_FIXED)
                        s_d.en[idx] = bus_wdata[0];
                end
                FLD_PRIO: begin
                    if (is_banked(32'(idx)))
                        s_d.prio_bk[bus_cpu][idx] = bus_wdata[7:4];
                    else
                        s_d.prio_sh[idx] = bus_wdata[7:4];
                end
                FLD_TARGET: begin
                    // read-only field
                end
                FLD_CONFIG: begin
                    if (!is_locked_cfg(32'(idx))) begin
                        s_d.shared[idx] = bus_wdata[0];
                        if (32'(idx) >= LOW_FIXED)
                            s_d.trig_edge[idx] = bus_wdata[1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    // read mux
    always_comb begin
        bus_rdata = 8'h00;
        if (in_range) begin
            case (field_e'(bus_field))
                FLD_ENABLE: bus_rdata = {7'b0, s_q.en[idx]};
                FLD_PRIO: begin
                    if (is_banked(32'(idx)))
                        bus_rdata = {s_q.prio_bk[bus_cpu][idx], 4'h0};
                    else
                        bus_rdata = {s_q.prio_sh[idx], 4'h0};
                end
                FLD_TARGET: begin
                    if (is_self_target(32'(idx)))
                        bus_rdata = 8'(1 << bus_cpu);
                end
                FLD_CONFIG: bus_rdata = {6'b0, s_q.trig_edge[idx], s_q.shared[idx]};
                default: bus_rdata = 8'h00;
            endcase
        end
    end

    // effective per-CPU priority view
    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                prio_o[c][i] = is_banked(i) ? s_q.prio_bk[c][i] : s_q.prio_sh[i];
            end
        end
    end

    assign en_o     = s_q.en;
    assign edge_o   = s_q.trig_edge;
    assign shared_o = s_q.shared;

endmodule

// File: rtl/irqdist_pending.sv
`timescale 1ns/1ps
module irqdist_pending #(
    parameter int NCPU    = 4,
    parameter int NUM_IRQ = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_IRQ-1:0]               irq_in,
    input  logic [NUM_IRQ-1:0]               edge_cfg,
    input  logic [NUM_IRQ-1:0]               shared_cfg,
    input  logic [NCPU-1:0][NUM_IRQ-1:0]     take,
    output logic [NCPU-1:0][NUM_IRQ-1:0]     pend_o
);

    typedef struct packed {
        logic [NUM_IRQ-1:0]           prev;
        logic [NCPU-1:0][NUM_IRQ-1:0] pend;
    } pend_t;

    pend_t s_d, s_q;

    logic [NUM_IRQ-1:0] rise;
    logic [NUM_IRQ-1:0] set_v;
    logic [NUM_IRQ-1:0] any_take;
    logic [NUM_IRQ-1:0] clr;

    always_comb begin
        s_d      = s_q;
        rise     = irq_in & ~s_q.prev;
        set_v    = (edge_cfg & rise) | (~edge_cfg & irq_in);
        any_take = '0;
        clr      = '0;
        for (int c = 0; c < NCPU; c++)
            any_take = any_take | take[c];
        for (int c = 0; c < NCPU; c++) begin
            clr = (shared_cfg & any_take) | (~shared_cfg & take[c]);
            // a fresh set in the acknowledge cycle outranks the clear
            s_d.pend[c] = set_v | (s_q.pend[c] & ~clr);
        end
        s_d.prev = irq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = s_q.pend;

endmodule

// File: rtl/irqdist_arbiter.sv
`timescale 1ns/1ps
module irqdist_arbiter
    import irqdist_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0]       pend,
    input  logic [NUM_IRQ-1:0]       en,
    input  logic [NUM_IRQ-1:0][3:0]  prio,
    output logic                     valid,
    output logic [ID_W-1:0]          sel_id
);

    logic [3:0]      best;
    logic [ID_W-1:0] best_id;
    logic            found;

    always_comb begin
        best    = PRIO_MASK;
        best_id = '0;
        found   = 1'b0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend[i] && en[i] && (prio[i] != PRIO_MASK)) begin
                // strict compare keeps the lower ID on a tie
                if (!found || (prio[i] < best)) begin
                    best    = prio[i];
                    best_id = ID_W'(i);
                    found   = 1'b1;
                end
            end
        end
        valid  = found;
        sel_id = found ? best_id : NO_IRQ_ID;
    end

endmodule

// File: rtl/irqdist_top.sv
`timescale 1ns/1ps
module irqdist_top
    import irqdist_pkg::*;
#(
    parameter int NCPU    = 4,
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 6,
    localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [CPU_W-1:0]        bus_cpu,
    input  logic [1:0]              bus_field,
    input  logic [ADDR_W-1:0]       bus_id,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [NUM_IRQ-1:0]      irq_in,
    input  logic [NCPU-1:0]         ack,
    output logic [NCPU-1:0]         cpu_irq,
    output logic [NCPU*ID_W-1:0]    ack_id
);

    logic [NUM_IRQ-1:0]                en_w;
    logic [NUM_IRQ-1:0]                edge_w;
    logic [NUM_IRQ-1:0]                shared_w;
    logic [NCPU-1:0][NUM_IRQ-1:0][3:0] prio_w;
    logic [NCPU-1:0][NUM_IRQ-1:0]      pend_w;
    logic [NCPU-1:0][NUM_IRQ-1:0]      take_w;
    logic [NCPU-1:0]                   valid_w;
    logic [NCPU-1:0][ID_W-1:0]         sel_w;

    irqdist_regs #(
        .NCPU    (NCPU),
        .NUM_IRQ (NUM_IRQ),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_cpu   (bus_cpu),
        .bus_field (bus_field),
        .bus_id    (bus_id),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_o      (en_w),
        .edge_o    (edge_w),
        .shared_o  (shared_w),
        .prio_o    (prio_w)
    );

    irqdist_pending #(
        .NCPU    (NCPU),
        .NUM_IRQ (NUM_IRQ)
    ) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .edge_cfg   (edge_w),
        .shared_cfg (shared_w),
        .take       (take_w),
        .pend_o     (pend_w)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        irqdist_arbiter #(
            .NUM_IRQ (NUM_IRQ)
        ) u_arb (
            .pend   (pend_w[c]),
            .en     (en_w),
            .prio   (prio_w[c]),
            .valid  (valid_w[c]),
            .sel_id (sel_w[c])
        );
        assign ack_id[c*ID_W +: ID_W] = sel_w[c];
    end

    // acknowledge decode: one-hot take vector per CPU
    always_comb begin
        take_w = '0;
        for (int c = 0; c < NCPU; c++) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                take_w[c][i] = ack[c] && valid_w[c] && (sel_w[c] == ID_W'(i));
            end
        end
    end

    assign cpu_irq = valid_w;

endmodule

// File: rtl/irqdist_checker.sv
`timescale 1ns/1ps
module irqdist_checker #(
    parameter int NCPU    = 4,
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 6,
    localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [CPU_W-1:0]    bus_cpu,
    input logic [1:0]          bus_field,
    input logic [ADDR_W-1:0]   bus_id,
    input logic [7:0]          bus_rdata,
    input logic [NCPU-1:0]     cpu_irq,
    input logic [NCPU*10-1:0]  ack_id
);

    logic rd_en;
    assign rd_en = bus_valid && !bus_write;

    AST_FIXED_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_field == 2'd0 && 32'(bus_id) < 16) |-> (bus_rdata == 8'h01)); // R5

    AST_SELF_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_field == 2'd2 && 32'(bus_id) >= 29 && 32'(bus_id) < NUM_IRQ)
        |-> (bus_rdata == 8'(1 << bus_cpu))); // R7

    AST_LOCKED_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_field == 2'd3 && (32'(bus_id) == 29 || 32'(bus_id) == 30))
        |-> (bus_rdata == 8'h02)); // R8

    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && 32'(bus_id) >= NUM_IRQ) |-> (bus_rdata == 8'h00)); // R9

    for (genvar c = 0; c < NCPU; c++) begin : g_idle
        AST_IDLE_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            !cpu_irq[c] |-> (ack_id[c*10 +: 10] == 10'd1023)); // R10
    end

endmodule

bind irqdist_top irqdist_checker #(
    .NCPU    (NCPU),
    .NUM_IRQ (NUM_IRQ),
    .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/irqdist_top_bench.sv
`timescale 1ns/1ps
module irqdist_top_bench;

    localparam int NCPU = 4;
    localparam int NIRQ = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [1:0]        bus_cpu = '0;
    logic [1:0]        bus_field = '0;
    logic [5:0]        bus_id = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [NIRQ-1:0]   irq_in = '0;
    logic [NCPU-1:0]   ack = '0;
    logic [NCPU-1:0]   cpu_irq;
    logic [NCPU*10-1:0] ack_id;

    irqdist_top #(.NCPU(NCPU), .NUM_IRQ(NIRQ), .ADDR_W(6)) u_irqdist_top (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_cpu(bus_cpu), .bus_field(bus_field), .bus_id(bus_id),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .ack(ack), .cpu_irq(cpu_irq), .ack_id(ack_id)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    // item kinds: 0 = read data, 1 = ack_id of cpu, 2 = request line of cpu
    typedef struct { int kind; int cpu; int exp; string tag; } item_t;
    item_t q[$];
    event  obs_ev;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // monitor
    initial begin
        forever begin
            @(obs_ev);
            while (q.size() > 0) begin
                item_t it;
                int    got;
                it = q.pop_front();
                case (it.kind)
                    0:       got = int'(bus_rdata);
                    1:       got = int'(ack_id[it.cpu*10 +: 10]);
                    default: got = int'(cpu_irq[it.cpu]);
                endcase
                n_cmp++;
                if (got != it.exp) begin
                    n_bad++;
                    $display("FAIL %s: kind %0d cpu %0d actual %0d expected %0d",
                             it.tag, it.kind, it.cpu, got, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input int cpu, input int exp, input string tag);
        item_t it;
        it.kind = kind; it.cpu = cpu; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic observe();
        -> obs_ev;
        #0.5;
    endtask

    task automatic wr(input int cpu, input int fld, input int id, input int data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_cpu = 2'(cpu);
        bus_field = 2'(fld); bus_id = 6'(id); bus_wdata = 8'(data);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int cpu, input int fld, input int id, input int exp, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_cpu = 2'(cpu);
        bus_field = 2'(fld); bus_id = 6'(id);
        #0.5;
        push(0, cpu, exp, tag);
        observe();
        bus_valid = 1'b0;
    endtask

    task automatic chk_cpu(input int cpu, input int exp_irq, input int exp_id, input string tag);
        #0.5;
        push(2, cpu, exp_irq, tag);
        push(1, cpu, exp_id, tag);
        observe();
    endtask

    task automatic pulse(input int id);
        @(negedge clk); irq_in[id] = 1'b1;
        @(negedge clk); irq_in[id] = 1'b0;
    endtask

    task automatic ack_one(input int cpu, input int exp_id, input string tag);
        @(negedge clk);
        ack[cpu] = 1'b1;
        #0.5;
        push(1, cpu, exp_id, tag);
        observe();
        @(negedge clk);
        ack[cpu] = 1'b0;
    endtask

    task automatic drain();
        for (int c = 0; c < NCPU; c++) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (cpu_irq[c]) begin
                    ack[c] = 1'b1;
                    @(negedge clk);
                    ack[c] = 1'b0;
                end
            end
        end
    endtask

    // driver
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NCPU; c++) chk_cpu(c, 0, 1023, "R10 reset idle");

        // enable field of low IDs is fixed
        rd(0, 0, 5, 1, "R5 low enable reads one");
        wr(1, 0, 5, 0);
        rd(1, 0, 5, 1, "R5 low enable write ignored");
        rd(0, 0, 20, 0, "R5 upper enable resets to zero");

        // target field
        rd(2, 2, 30, 4, "R7 target one-hot cpu2");
        rd(1, 2, 31, 2, "R7 target one-hot cpu1");
        rd(3, 2, 10, 0, "R7 target low ID zero");
        wr(0, 2, 12, 8'hFF);
        rd(0, 2, 12, 0, "R7 target write ignored");

        // configuration field
        rd(0, 3, 3, 2, "R8 low cfg edge");
        wr(0, 3, 3, 0);
        rd(0, 3, 3, 2, "R8 low cfg upper bit fixed");
        wr(0, 3, 3, 1);
        rd(0, 3, 3, 3, "R8 low cfg lower bit writable");
        wr(0, 3, 29, 1);
        rd(0, 3, 29, 2, "R8 id29 cfg locked");
        rd(1, 3, 30, 2, "R8 id30 cfg locked");
        wr(0, 3, 21, 3);
        rd(0, 3, 21, 3, "R8 upper cfg writable");

        // out of range
        wr(0, 0, 40, 1);
        wr(0, 1, 40, 8'h50);
        rd(0, 0, 40, 0, "R9 oor enable");
        rd(0, 1, 40, 0, "R9 oor prio");
        rd(0, 3, 40, 0, "R9 oor cfg");

        // banked / shared priority
        wr(0, 1, 5, 8'h37);
        rd(0, 1, 5, 8'h30, "R4 low nibble dropped");
        rd(1, 1, 5, 8'h00, "R6 banked copy other cpu");
        wr(0, 1, 20, 8'h50);
        rd(1, 1, 20, 8'h50, "R6 shared prio visible");

        // private model edge
        wr(0, 3, 3, 2);
        pulse(3);
        for (int c = 0; c < NCPU; c++) chk_cpu(c, 1, 3, "R1 edge sets pending");
        ack_one(0, 3, "R11 ack returns id");
        chk_cpu(0, 0, 1023, "R3 taker cleared");
        chk_cpu(1, 1, 3, "R3 other cpu kept");
        drain();

        // shared model
        wr(0, 3, 4, 3);
        pulse(4);
        chk_cpu(3, 1, 4, "R2 shared pending");
        ack_one(2, 4, "R2 shared ack");
        for (int c = 0; c < NCPU; c++) chk_cpu(c, 0, 1023, "R2 cleared everywhere");

        // level trigger
        wr(0, 0, 20, 1);
        @(negedge clk); irq_in[20] = 1'b1;
        @(negedge clk);
        chk_cpu(0, 1, 20, "R1 level pending");
        ack_one(0, 20, "R1 level ack");
        chk_cpu(0, 1, 20, "R1 level stays while high");
        irq_in[20] = 1'b0;
        drain();
        chk_cpu(0, 0, 1023, "R1 level cleared after drop");

        // disabled ID
        @(negedge clk); irq_in[22] = 1'b1;
        @(negedge clk);
        chk_cpu(1, 0, 1023, "R5 disabled not signalled");
        wr(0, 0, 22, 1);
        chk_cpu(1, 1, 22, "R5 enabled now signalled");
        irq_in[22] = 1'b0;
        drain();

        // priority order and ties
        wr(0, 1, 6, 8'h30);
        @(negedge clk); irq_in[6] = 1'b1; irq_in[7] = 1'b1;
        @(negedge clk); irq_in[6] = 1'b0; irq_in[7] = 1'b0;
        chk_cpu(0, 1, 7, "R4 more urgent wins");
        chk_cpu(1, 1, 6, "R10 tie lower id");
        drain();

        // never-signal level
        wr(0, 1, 8, 8'hF0);
        pulse(8);
        chk_cpu(0, 0, 1023, "R4 prio F masked");
        chk_cpu(1, 1, 8, "R4 other cpu sees id");
        drain();

        // two CPUs acknowledge one shared ID together
        pulse(4);
        @(negedge clk);
        ack[0] = 1'b1; ack[1] = 1'b1;
        #0.5;
        push(1, 0, 4, "R2 joint ack cpu0");
        push(1, 1, 4, "R2 joint ack cpu1");
        observe();
        @(negedge clk);
        ack = '0;
        chk_cpu(2, 0, 1023, "R2 joint ack cleared cpu2");
        chk_cpu(3, 0, 1023, "R2 joint ack cleared cpu3");

        // acknowledge meets a fresh edge
        pulse(3);
        @(negedge clk);
        ack[0] = 1'b1; irq_in[3] = 1'b1;
        #0.5;
        push(1, 0, 3, "R11 ack with edge");
        observe();
        @(negedge clk);
        ack[0] = 1'b0; irq_in[3] = 1'b0;
        chk_cpu(0, 1, 3, "R11 new edge wins");
        ack_one(0, 3, "R11 second ack");
        chk_cpu(0, 0, 1023, "R11 cleared after second ack");
        drain();

        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule